// File: doc/BRIEF.md
# Hybrid SRAM/MRAM Line Placement Controller

This block makes the placement decisions for a set-associative cache whose ways are built from two memory technologies. A few ways per set are fast-write SRAM and the rest are slow-write MRAM. A fixed parameter mask records which ways are which. The block sees every access after the tag lookup has finished. It gets the set, the tag, whether the access is a read or a write, whether it hit, and the way that hit. From these it decides where a missing line is filled. It also decides when a line held in MRAM must move into SRAM.

Fills and moves leave the block as commands on a valid/ready stream. Requests arrive on a second valid/ready stream. A command stays on the output until the consumer takes it, and no new request is accepted while a command is waiting. A move is issued as one swap command. The command names the MRAM way the line comes from and the SRAM way it goes to. The SRAM line that was there before goes back into the vacated MRAM way. After a swap command has been taken, requests stay stalled until the data path pulses `mig_done`.

For each MRAM line the block keeps one bit recording whether the last access to it was a write. The SRAM target is picked by a round-robin pointer kept per set. Read misses are filled into MRAM using a second, separate round-robin pointer per set. Three counters are exposed so the behaviour can be observed.

Top module: `hyb_place_ctrl`

## Requirements
- R1: `region_map` always equals the static way mask. With the default mask 8'h03, ways 0 and 1 are SRAM (bit set) and ways 2 to 7 are MRAM.
- R2: A write miss produces a FILL command (`cmd_op`=0). Its destination is the set's SRAM round-robin way, and `cnt_sram_wr` increments. The pointer starts at the lowest SRAM way and moves to the next SRAM way in ascending cyclic order each time it is used.
- R3: A read miss produces a FILL command whose destination is the set's MRAM round-robin way. That pointer is separate from the SRAM one, starts at the lowest MRAM way and moves the same way. The counters do not change.
- R4: A write hit on an MRAM line that was last filled or read produces no command. It increments `cnt_mram_wr` and marks the line as last written.
- R5: A write hit on an MRAM line that was last written produces a SWAP command (`cmd_op`=1). The source is the hit way and the destination is the set's SRAM round-robin way. Both `cnt_mig` and `cnt_sram_wr` increment.
- R6: A read hit on an MRAM line clears its last-written mark. If `req_promote` is high, the read hit instead produces a SWAP into the SRAM round-robin way, and `cnt_mig` increments.
- R7: A write hit in an SRAM way increments `cnt_sram_wr` and produces no command. A read hit in an SRAM way changes nothing.
- R8: `cmd_victim_valid` reports whether the destination way held a valid line before the command. After a swap, the source MRAM way takes on that validity. A line moved into MRAM by a swap is marked as not last written.
- R9: `req_ready` is low while `cmd_valid` is high. While `cmd_valid` is high and `cmd_ready` is low, all command fields hold steady.
- R10: After a SWAP command is taken, `req_ready` stays low until a `mig_done` pulse arrives. A `mig_done` pulse at any other time is ignored.
- R11: After reset every line is invalid and not marked as written, the pointers are at their starting ways, the counters are zero, `cmd_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Line tag, copied into the command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hit | input | 1 | Tag lookup hit |
| req_hit_way | input | WAY_W | Way that hit |
| req_promote | input | 1 | A read hit on an MRAM line should move the line into SRAM |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command consumer ready |
| cmd_op | output | 1 | 0 = FILL, 1 = SWAP |
| cmd_set | output | SET_W | Set of the command |
| cmd_tag | output | TAG_W | Tag of the line being filled or moved |
| cmd_src_way | output | WAY_W | Source MRAM way of a SWAP (0 for FILL) |
| cmd_dst_way | output | WAY_W | Destination way |
| cmd_victim_valid | output | 1 | Destination way held a valid line |
| mig_done | input | 1 | Swap has finished in the data path |
| region_map | output | WAYS | 1 = SRAM way, 0 = MRAM way |
| cnt_sram_wr | output | CNT_W | Writes that landed in SRAM |
| cnt_mram_wr | output | CNT_W | Writes that landed in MRAM |
| cnt_mig | output | CNT_W | Swaps issued |

## Verification
A request accepted at a clock edge produces its command and its counter changes at that same edge. Both are visible from the next cycle, and `req_ready` falls in that same cycle. `req_ready` rises in the cycle after the command handshake for a FILL, and in the cycle after the `mig_done` pulse for a SWAP. The bench keeps a behavioural model that applies the same inputs to its own state between edges. It compares every output against the model at each falling edge, so any result that arrives in the wrong cycle shows up as a mismatch.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
  typedef enum logic {
    OP_FILL = 1'b0,
    OP_SWAP = 1'b1
  } hyb_op_e;
endpackage

// File: rtl/hyb_rr_bank.sv
module hyb_rr_bank #(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  parameter logic [WAYS-1:0] MASK = '1,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] victim_o
);
  function automatic logic [WAY_W-1:0] next_in_mask(input logic [WAY_W-1:0] cur);
    logic [WAY_W-1:0] r;
    logic found;
    r = cur;
    found = 1'b0;
    for (int i = 1; i <= WAYS; i++) begin
      int c;
      c = (int'(cur) + i) % WAYS;
      if (!found && MASK[c]) begin
        r = WAY_W'(c);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  localparam logic [WAY_W-1:0] FIRST = next_in_mask(WAY_W'(WAYS - 1));

  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= FIRST;
    end else if (adv_i) begin
      ptr_q[set_i] <= next_in_mask(ptr_q[set_i]);
    end
  end

  assign victim_o = ptr_q[set_i];

  // R2 / R3: the pointer never leaves its own region
  assert_victim_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    MASK[victim_o]);
endmodule

// File: rtl/hyb_line_state.sv
module hyb_line_state #(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             wa_en,
  input  logic [WAY_W-1:0] wa_way,
  input  logic             wa_valid,
  input  logic             wa_flag,
  input  logic             wb_en,
  input  logic [WAY_W-1:0] wb_way,
  input  logic             wb_valid,
  input  logic             wb_flag,
  output logic [WAYS-1:0]  valid_row,
  output logic [WAYS-1:0]  flag_row
);
  logic [WAYS-1:0] valid_q [SETS];
  logic [WAYS-1:0] flag_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        flag_q[s]  <= '0;
      end
    end else begin
      if (wa_en) begin
        valid_q[set_i][wa_way] <= wa_valid;
        flag_q[set_i][wa_way]  <= wa_flag;
      end
      if (wb_en) begin
        valid_q[set_i][wb_way] <= wb_valid;
        flag_q[set_i][wb_way]  <= wb_flag;
      end
    end
  end

  assign valid_row = valid_q[set_i];
  assign flag_row  = flag_q[set_i];

  // R8: both update ports never aim at the same line
  assert_ports_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_way != wb_way));
endmodule

// File: rtl/hyb_cmd_reg.sv
module hyb_cmd_reg #(
  parameter int SET_W = 4,
  parameter int TAG_W = 20,
  parameter int WAY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             op_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [WAY_W-1:0] src_i,
  input  logic [WAY_W-1:0] dst_i,
  input  logic             vv_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             op_o,
  output logic [SET_W-1:0] set_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [WAY_W-1:0] src_o,
  output logic [WAY_W-1:0] dst_o,
  output logic             vv_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      op_o    <= 1'b0;
      set_o   <= '0;
      tag_o   <= '0;
      src_o   <= '0;
      dst_o   <= '0;
      vv_o    <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      op_o    <= op_i;
      set_o   <= set_i;
      tag_o   <= tag_i;
      src_o   <= src_i;
      dst_o   <= dst_i;
      vv_o    <= vv_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9: a stalled command keeps every field
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable({op_o, set_o, tag_o, src_o, dst_o, vv_o})));
endmodule

// File: rtl/hyb_place_ctrl.sv
module hyb_place_ctrl
  import hyb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 8,
  parameter int TAG_W = 20,
  parameter int CNT_W = 16,
  parameter logic [WAYS-1:0] SRAM_MASK = 8'h03,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_write,
  input  logic             req_hit,
  input  logic [WAY_W-1:0] req_hit_way,
  input  logic             req_promote,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_op,
  output logic [SET_W-1:0] cmd_set,
  output logic [TAG_W-1:0] cmd_tag,
  output logic [WAY_W-1:0] cmd_src_way,
  output logic [WAY_W-1:0] cmd_dst_way,
  output logic             cmd_victim_valid,
  input  logic             mig_done,
  output logic [WAYS-1:0]  region_map,
  output logic [CNT_W-1:0] cnt_sram_wr,
  output logic [CNT_W-1:0] cnt_mram_wr,
  output logic [CNT_W-1:0] cnt_mig
);
  logic [WAY_W-1:0] sram_vic, mram_vic;
  logic [WAYS-1:0]  valid_row, flag_row;
  logic             wait_q;
  logic             accept, hit_sram, hit_mram;
  logic             rep_write, promote, do_swap, fill_w, fill_r;
  logic             wr_sram, wr_mram;
  logic             wa_en, wa_valid, wa_flag, wb_en, wb_valid, wb_flag;
  logic [WAY_W-1:0] wa_way, wb_way;
  logic             ld, ld_op, ld_vv;
  logic [WAY_W-1:0] ld_src, ld_dst;

  assign region_map = SRAM_MASK;
  assign req_ready  = !cmd_valid && !wait_q;

  assign accept    = req_valid && req_ready;
  assign hit_sram  = req_hit && SRAM_MASK[req_hit_way];
  assign hit_mram  = req_hit && !SRAM_MASK[req_hit_way];
  assign rep_write = hit_mram && req_write && flag_row[req_hit_way];
  assign promote   = hit_mram && !req_write && req_promote;
  assign do_swap   = accept && (rep_write || promote);
  assign fill_w    = accept && req_write && !req_hit;
  assign fill_r    = accept && !req_write && !req_hit;
  assign wr_sram   = accept && req_write && (hit_sram || !req_hit || rep_write);
  assign wr_mram   = accept && req_write && hit_mram && !rep_write;

  hyb_rr_bank #(.SETS(SETS), .WAYS(WAYS), .MASK(SRAM_MASK)) u_sram_rr (
    .clk(clk), .rst_n(rst_n), .set_i(req_set),
    .adv_i(do_swap || fill_w), .victim_o(sram_vic));

  hyb_rr_bank #(.SETS(SETS), .WAYS(WAYS), .MASK(~SRAM_MASK)) u_mram_rr (
    .clk(clk), .rst_n(rst_n), .set_i(req_set),
    .adv_i(fill_r), .victim_o(mram_vic));

  always_comb begin
    wa_en = 1'b0; wa_way = '0; wa_valid = 1'b0; wa_flag = 1'b0;
    wb_en = 1'b0; wb_way = '0; wb_valid = 1'b0; wb_flag = 1'b0;
    ld = 1'b0; ld_op = OP_FILL; ld_src = '0; ld_dst = '0; ld_vv = 1'b0;
    if (fill_w || fill_r) begin
      ld     = 1'b1;
      ld_dst = fill_w ? sram_vic : mram_vic;
      ld_vv  = valid_row[ld_dst];
      wa_en  = 1'b1; wa_way = ld_dst; wa_valid = 1'b1;
    end else if (do_swap) begin
      ld     = 1'b1;
      ld_op  = OP_SWAP;
      ld_src = req_hit_way;
      ld_dst = sram_vic;
      ld_vv  = valid_row[sram_vic];
      wa_en  = 1'b1; wa_way = sram_vic; wa_valid = 1'b1;
      wb_en  = 1'b1; wb_way = req_hit_way; wb_valid = valid_row[sram_vic];
    end else if (accept && hit_mram) begin
      wa_en    = 1'b1;
      wa_way   = req_hit_way;
      wa_valid = valid_row[req_hit_way];
      wa_flag  = req_write;
    end
  end

  hyb_line_state #(.SETS(SETS), .WAYS(WAYS)) u_state (
    .clk(clk), .rst_n(rst_n), .set_i(req_set),
    .wa_en(wa_en), .wa_way(wa_way), .wa_valid(wa_valid), .wa_flag(wa_flag),
    .wb_en(wb_en), .wb_way(wb_way), .wb_valid(wb_valid), .wb_flag(wb_flag),
    .valid_row(valid_row), .flag_row(flag_row));

  hyb_cmd_reg #(.SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .op_i(ld_op), .set_i(req_set),
    .tag_i(req_tag), .src_i(ld_src), .dst_i(ld_dst), .vv_i(ld_vv),
    .ready_i(cmd_ready), .valid_o(cmd_valid), .op_o(cmd_op), .set_o(cmd_set),
    .tag_o(cmd_tag), .src_o(cmd_src_way), .dst_o(cmd_dst_way), .vv_o(cmd_victim_valid));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q      <= 1'b0;
      cnt_sram_wr <= '0;
      cnt_mram_wr <= '0;
      cnt_mig     <= '0;
    end else begin
      if (wait_q) begin
        if (mig_done) wait_q <= 1'b0;
      end else if (cmd_valid && cmd_ready && cmd_op == OP_SWAP) begin
        wait_q <= 1'b1;
      end
      if (wr_sram) cnt_sram_wr <= cnt_sram_wr + 1'b1;
      if (wr_mram) cnt_mram_wr <= cnt_mram_wr + 1'b1;
      if (do_swap) cnt_mig     <= cnt_mig + 1'b1;
    end
  end

  // R2: write miss fills an SRAM way next cycle
  assert_write_fill_sram_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !req_hit) |=>
      (cmd_valid && cmd_op == OP_FILL && SRAM_MASK[cmd_dst_way]));
  // R3: read miss fills an MRAM way next cycle
  assert_read_fill_mram_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !req_hit) |=>
      (cmd_valid && cmd_op == OP_FILL && !SRAM_MASK[cmd_dst_way]));
  // R5: swaps move from MRAM into SRAM
  assert_swap_regions_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SWAP) |-> (SRAM_MASK[cmd_dst_way] && !SRAM_MASK[cmd_src_way]));
  // R5: a fresh swap command comes with a migration count step
  assert_swap_counted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_op == OP_SWAP) |-> (cnt_mig != $past(cnt_mig)));
  // R9: no request taken while a command waits
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
  // R10: a taken swap stalls requests in the next cycle
  assert_swap_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_SWAP) |=> !req_ready);
endmodule

// File: tb/hyb_place_ctrl_bench.sv
module hyb_place_ctrl_bench;
  localparam int SETS = 16;
  localparam int WAYS = 8;
  localparam int TAG_W = 20;
  localparam int CNT_W = 16;
  localparam logic [7:0] MAP = 8'h03;  // R1: ways 0,1 SRAM

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic req_valid = 0, req_write = 0, req_hit = 0, req_promote = 0;
  logic [3:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [2:0] req_hit_way = '0;
  logic cmd_ready = 0, mig_done = 0;
  logic req_ready, cmd_valid, cmd_op, cmd_victim_valid;
  logic [3:0] cmd_set;
  logic [TAG_W-1:0] cmd_tag;
  logic [2:0] cmd_src_way, cmd_dst_way;
  logic [7:0] region_map;
  logic [CNT_W-1:0] cnt_sram_wr, cnt_mram_wr, cnt_mig;

  hyb_place_ctrl u_hyb_place_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_tag(req_tag), .req_write(req_write), .req_hit(req_hit),
    .req_hit_way(req_hit_way), .req_promote(req_promote), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_set(cmd_set), .cmd_tag(cmd_tag),
    .cmd_src_way(cmd_src_way), .cmd_dst_way(cmd_dst_way),
    .cmd_victim_valid(cmd_victim_valid), .mig_done(mig_done),
    .region_map(region_map), .cnt_sram_wr(cnt_sram_wr), .cnt_mram_wr(cnt_mram_wr),
    .cnt_mig(cnt_mig));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_valid [SETS][WAYS];
  int m_flag  [SETS][WAYS];
  int m_sptr [SETS];
  int m_mptr [SETS];
  int e_ready, e_cvalid, e_op, e_set, e_tag, e_src, e_dst, e_vv, e_wait;
  int e_sram, e_mram, e_mig;
  string e_req;

  function automatic bit is_sram(int w);
    return MAP[w];
  endfunction

  function automatic int next_way(int cur, bit want_sram);
    for (int i = 1; i <= WAYS; i++) begin
      int c;
      c = (cur + i) % WAYS;
      if (is_sram(c) == want_sram) return c;
    end
    return cur;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(region_map == MAP, "R1", "region_map", region_map, MAP);
    check(req_ready == e_ready, "R10", "req_ready", req_ready, e_ready);
    check(cmd_valid == e_cvalid, "R9", "cmd_valid", cmd_valid, e_cvalid);
    if (e_cvalid) begin
      check(cmd_op == e_op, e_req, "cmd_op", cmd_op, e_op);
      check(cmd_set == e_set, e_req, "cmd_set", cmd_set, e_set);
      check(cmd_tag == e_tag, e_req, "cmd_tag", cmd_tag, e_tag);
      check(cmd_src_way == e_src, e_req, "cmd_src_way", cmd_src_way, e_src);
      check(cmd_dst_way == e_dst, e_req, "cmd_dst_way", cmd_dst_way, e_dst);
      check(cmd_victim_valid == e_vv, "R8", "cmd_victim_valid", cmd_victim_valid, e_vv);
    end
    check(cnt_sram_wr == e_sram, "R7", "cnt_sram_wr", cnt_sram_wr, e_sram);
    check(cnt_mram_wr == e_mram, "R4", "cnt_mram_wr", cnt_mram_wr, e_mram);
    check(cnt_mig == e_mig, "R5", "cnt_mig", cnt_mig, e_mig);
  endtask

  task automatic model_swap(int s, int w, int tag, string req);
    int d;
    d = m_sptr[s];
    e_cvalid = 1; e_op = 1; e_set = s; e_tag = tag; e_src = w; e_dst = d;
    e_vv = m_valid[s][d]; e_req = req;
    m_valid[s][w] = m_valid[s][d]; m_flag[s][w] = 0;  // R8
    m_valid[s][d] = 1; m_flag[s][d] = 0;
    m_sptr[s] = next_way(d, 1);
    e_mig++;
  endtask

  task automatic model_accept(int s, int tag, bit wr, bit hit, int w, bit prom);
    if (!hit) begin
      int d;
      d = wr ? m_sptr[s] : m_mptr[s];
      e_cvalid = 1; e_op = 0; e_set = s; e_tag = tag; e_src = 0; e_dst = d;
      e_vv = m_valid[s][d]; e_req = wr ? "R2" : "R3";
      m_valid[s][d] = 1; m_flag[s][d] = 0;
      if (wr) begin m_sptr[s] = next_way(d, 1); e_sram++; end
      else m_mptr[s] = next_way(d, 0);
    end else if (is_sram(w)) begin
      if (wr) e_sram++;  // R7
    end else if (wr && m_flag[s][w] != 0) begin
      model_swap(s, w, tag, "R5");
      e_sram++;
    end else if (wr) begin
      m_flag[s][w] = 1; e_mram++;  // R4
    end else if (prom) begin
      model_swap(s, w, tag, "R6");
    end else begin
      m_flag[s][w] = 0;  // R6
    end
  endtask

  task automatic cycle(bit v, int s, int tag, bit wr, bit hit, int w, bit prom, bit crdy, bit done);
    bit acc, cacc;
    req_valid = v; req_set = 4'(s); req_tag = TAG_W'(tag); req_write = wr;
    req_hit = hit; req_hit_way = 3'(w); req_promote = prom;
    cmd_ready = crdy; mig_done = done;
    acc  = v && (e_ready != 0);
    cacc = (e_cvalid != 0) && crdy;
    if (e_wait != 0) begin
      if (done) e_wait = 0;
    end else if (cacc && e_op == 1) e_wait = 1;
    if (cacc) e_cvalid = 0;
    if (acc) model_accept(s, tag, wr, hit, w, prom);
    e_ready = (e_cvalid == 0 && e_wait == 0) ? 1 : 0;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  // issue one request, then drain it (command taken, swap completed)
  task automatic req(int s, int tag, bit wr, bit hit, int w, bit prom);
    while (e_ready == 0) cycle(0, 0, 0, 0, 0, 0, 0, 1, 1);
    cycle(1, s, tag, wr, hit, w, prom, 1, 0);
    while (e_ready == 0) cycle(0, 0, 0, 0, 0, 0, 0, 1, 1);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_sptr[s] = 0; m_mptr[s] = 2;
      for (int w = 0; w < WAYS; w++) begin m_valid[s][w] = 0; m_flag[s][w] = 0; end
    end
    e_ready = 1; e_cvalid = 0; e_op = 0; e_set = 0; e_tag = 0; e_src = 0; e_dst = 0;
    e_vv = 0; e_wait = 0; e_sram = 0; e_mram = 0; e_mig = 0; e_req = "R2";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    check(req_ready == 1 && cmd_valid == 0, "R11", "ready/valid after reset",
          {req_ready, cmd_valid}, 2);
    check(cnt_sram_wr == 0 && cnt_mram_wr == 0 && cnt_mig == 0, "R11", "counters",
          cnt_sram_wr + cnt_mram_wr + cnt_mig, 0);
    compare_all();

    // directed: set 5
    req(5, 11, 1, 0, 0, 0);  // R2 write miss -> way 0
    req(5, 12, 1, 0, 0, 0);  // R2 -> way 1
    req(5, 13, 1, 0, 0, 0);  // R2 -> way 0 again, victim valid (R8)
    req(5, 14, 0, 0, 0, 0);  // R3 read miss -> way 2
    req(5, 14, 1, 1, 2, 0);  // R4 first write on MRAM line
    req(5, 14, 1, 1, 2, 0);  // R5 second write -> swap
    req(5, 15, 0, 0, 0, 0);  // R3 -> way 3
    req(5, 15, 0, 1, 3, 1);  // R6 promoted read -> swap
    req(5, 16, 0, 0, 0, 0);  // R3 -> way 4
    req(5, 16, 1, 1, 4, 0);  // R4
    req(5, 16, 0, 1, 4, 0);  // R6 read clears mark
    req(5, 16, 1, 1, 4, 0);  // R4 again, no swap
    req(5, 17, 1, 1, 0, 0);  // R7 SRAM write hit
    req(5, 17, 0, 1, 1, 1);  // R7 SRAM read hit ignored
    // R9: back-pressure on a fill
    cycle(1, 6, 20, 1, 0, 0, 0, 0, 0);
    repeat (4) cycle(1, 6, 21, 0, 0, 0, 0, 0, 1);  // R10: stray done ignored
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R10: swap waits for done
    req(6, 22, 0, 0, 0, 0);
    req(6, 22, 1, 1, 2, 0);
    cycle(1, 6, 22, 1, 1, 2, 0, 1, 0);
    repeat (3) cycle(1, 6, 23, 0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 1);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v, wr, hit, prom, crdy, done;
      v    = ($urandom % 10) < 7;
      wr   = $urandom % 2;
      hit  = ($urandom % 10) < 6;
      prom = ($urandom % 10) < 3;
      crdy = ($urandom % 10) < 7;
      done = (e_wait != 0) ? (($urandom % 10) < 4) : (($urandom % 10) < 1);
      cycle(v, $urandom % 4, $urandom % 1000, wr, hit, $urandom % 8, prom, crdy, done);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule